// File: doc/BRIEF.md
# TLB Translation Request Coalescer

This block sits between a set of requester ports and a translation lookaside buffer. Each requester presents a virtual address with a tag. Requests that fall in the same virtual page during the same time window are gathered into one group, and each group costs a single TLB lookup. When the TLB answers a lookup, the block returns one response per gathered request. Every response holds the translated physical address, the port the request came in on and the tag the requester gave it.

Time is split into windows of `WIN` cycles. The window key of a request is the cycle of its acceptance, counted from reset, divided by `WIN`. A group stays open for merging until its window closes. From the cycle after that it can be issued. At most `LANES` lookups leave per cycle, and the oldest group takes the lowest lane. Each group occupies one of `SLOTS` slot machines. A slot walks through FREE → PENDING (on allocation by a new request) → OUTSTANDING (when issued to the TLB) → FANOUT (when the TLB response naming the slot arrives) → CLEANUP (after its last member response) → FREE (one cycle later). A lookup carries the slot index as its identifier, and the TLB echoes that identifier back with the physical page number. When `coalesce_off` is high, no request joins an existing group.

Top module: `tlb_req_coalescer`

## Requirements
- R1: With `coalesce_off` low, requests accepted in the same window whose addresses share the virtual page (address bits above the low `PGB` offset bits) produce exactly one TLB lookup.
- R2: A request accepted in cycle t (cycles counted from the first clock after reset) belongs to window t/WIN. Its lookup appears no earlier than cycle (t/WIN+1)·WIN, and exactly then when issue lanes are free. Requests for one page in different windows produce separate lookups.
- R3: No more than `LANES` lookups are presented in one cycle. Eligible groups beyond that wait for the next cycle.
- R4: With `coalesce_off` high, every accepted request produces its own lookup.
- R5: Groups are issued oldest first. Lane 0 carries the oldest eligible group, and within a window groups leave in the order they were created.
- R6: A request for a page whose lookup is already outstanding starts a new group and a new lookup. It is never added to the outstanding one.
- R7: A TLB response for slot id i produces one response per member of that group. They come one per cycle, starting the cycle after the TLB response, in acceptance order. Each carries the member's port and tag, and `resp_paddr` = {returned physical page, member's own page offset}.
- R8: `req_ready` is low for the granted port when its page matches a pending group that already holds `MEMB` members, or when it needs a new group and no slot is FREE.
- R9: At most one request is accepted per cycle. Among valid ports, the lowest index is granted and every other port sees `req_ready` low.
- R10: A slot is released in the cycle after its last member response. Once all responses are out, `SLOTS` new groups are accepted without stalling.
- R11: After reset, no lookup and no response is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| coalesce_off | input | 1 | When high, no request joins an existing group |
| req_valid | input | NPORT | Per-port request valid |
| req_ready | output | NPORT | Per-port request accepted this cycle |
| req_vaddr | input | NPORT*VAW | Per-port virtual address, port p at bits p*VAW |
| req_tag | input | NPORT*TAGW | Per-port requester tag |
| lk_valid | output | LANES | Lookup lane valid |
| lk_vpn | output | LANES*(VAW-PGB) | Virtual page number per lane |
| lk_id | output | LANES*IDW | Slot identifier per lane |
| tr_valid | input | 1 | TLB response valid |
| tr_id | input | IDW | Slot identifier echoed by the TLB |
| tr_ppn | input | PPNW | Physical page number |
| resp_valid | output | 1 | Member response valid |
| resp_port | output | PORTW | Port of the member |
| resp_tag | output | TAGW | Tag of the member |
| resp_paddr | output | PPNW+PGB | Translated physical address |

## Verification
A slot left in the wrong state has one of two effects at the ports. It may stop granting, so `req_ready` stays low for new pages. Or it may never leave FANOUT or OUTSTANDING, so responses go missing or come back twice. Either shows within a few windows. A wrong member counter or fan-out index gives a wrong offset, tag or response count in the first burst after that group's TLB response. A broken order queue or window key moves a lookup to the wrong cycle or lane, which shows up in the cycle the window closes.

// File: rtl/coal_pkg.sv
`timescale 1ns/1ps
package coal_pkg;
    typedef enum logic [2:0] {
        SL_FREE,
        SL_PEND,
        SL_OUT,
        SL_FAN,
        SL_CLEAN
    } slot_st_e;
endpackage

// File: rtl/coal_slot.sv
`timescale 1ns/1ps
module coal_slot
    import coal_pkg::*;
#(
    parameter int VPNW  = 20,
    parameter int PPNW  = 20,
    parameter int OFFW  = 12,
    parameter int PORTW = 2,
    parameter int TAGW  = 4,
    parameter int KEYW  = 8,
    parameter int MEMB  = 4,
    parameter int CNTW  = $clog2(MEMB + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc_i,
    input  logic             join_i,
    input  logic             issue_i,
    input  logic             hit_i,
    input  logic             pop_i,
    input  logic [VPNW-1:0]  vpn_i,
    input  logic [KEYW-1:0]  key_i,
    input  logic [OFFW-1:0]  off_i,
    input  logic [PORTW-1:0] port_i,
    input  logic [TAGW-1:0]  tag_i,
    input  logic [PPNW-1:0]  ppn_i,
    output slot_st_e         st_o,
    output logic [VPNW-1:0]  vpn_o,
    output logic [KEYW-1:0]  key_o,
    output logic             full_o,
    output logic [PPNW-1:0]  ppn_o,
    output logic [OFFW-1:0]  off_o,
    output logic [PORTW-1:0] port_o,
    output logic [TAGW-1:0]  tag_o
);
    localparam int MW = (MEMB > 1) ? $clog2(MEMB) : 1;

    slot_st_e         st_q, st_d;
    logic [CNTW-1:0]  cnt_q, fidx_q;
    logic [OFFW-1:0]  m_off  [MEMB];
    logic [PORTW-1:0] m_port [MEMB];
    logic [TAGW-1:0]  m_tag  [MEMB];
    logic             last;

    assign last = (CNTW'(fidx_q + 1'b1) == cnt_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= SL_FREE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            SL_FREE:  if (alloc_i)         st_d = SL_PEND;
            SL_PEND:  if (issue_i)         st_d = SL_OUT;
            SL_OUT:   if (hit_i)           st_d = SL_FAN;
            SL_FAN:   if (pop_i && last)   st_d = SL_CLEAN;
            SL_CLEAN:                      st_d = SL_FREE;
            default:                       st_d = SL_FREE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            fidx_q <= '0;
        end else begin
            if (alloc_i)     cnt_q <= CNTW'(1);
            else if (join_i) cnt_q <= cnt_q + 1'b1;
            if (hit_i)       fidx_q <= '0;
            else if (pop_i)  fidx_q <= fidx_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (alloc_i) begin
            vpn_o     <= vpn_i;
            key_o     <= key_i;
            m_off[0]  <= off_i;
            m_port[0] <= port_i;
            m_tag[0]  <= tag_i;
        end
        if (join_i) begin
            m_off[cnt_q[MW-1:0]]  <= off_i;
            m_port[cnt_q[MW-1:0]] <= port_i;
            m_tag[cnt_q[MW-1:0]]  <= tag_i;
        end
        if (hit_i) ppn_o <= ppn_i;
    end

    assign st_o   = st_q;
    assign full_o = (cnt_q == CNTW'(MEMB));
    assign off_o  = m_off[fidx_q[MW-1:0]];
    assign port_o = m_port[fidx_q[MW-1:0]];
    assign tag_o  = m_tag[fidx_q[MW-1:0]];

    AST_ALLOC_ONLY_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_i |-> st_q == SL_FREE); // R8
    AST_JOIN_NOT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        join_i |-> (st_q == SL_PEND && !full_o)); // R8
    AST_ISSUE_ONLY_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        issue_i |-> st_q == SL_PEND); // R5
    AST_HIT_ONLY_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        hit_i |-> st_q == SL_OUT); // R7
endmodule

// File: rtl/coal_order_fifo.sv
`timescale 1ns/1ps
module coal_order_fifo #(
    parameter int DEPTH = 4,
    parameter int IDW   = 2,
    parameter int LANES = 2,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           push_i,
    input  logic [IDW-1:0] push_id_i,
    input  logic [CW-1:0]  pop_n_i,
    output logic [IDW-1:0] lane_id_o [LANES],
    output logic           lane_ok_o [LANES]
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [IDW-1:0] mem [DEPTH];
    logic [PW-1:0]  rd_q, wr_q;
    logic [CW-1:0]  cnt_q;

    function automatic logic [PW-1:0] wrap(input logic [PW-1:0] b, input int n);
        int t;
        t = int'(b) + n;
        if (t >= DEPTH) t = t - DEPTH;
        return PW'(t);
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q  <= '0;
            wr_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push_i) wr_q <= wrap(wr_q, 1);
            rd_q  <= wrap(rd_q, int'(pop_n_i));
            cnt_q <= cnt_q + CW'(push_i) - pop_n_i;
        end
    end

    always_ff @(posedge clk) begin
        if (push_i) mem[wr_q] <= push_id_i;
    end

    always_comb begin
        for (int l = 0; l < LANES; l++) begin
            lane_id_o[l] = mem[wrap(rd_q, l)];
            lane_ok_o[l] = int'(cnt_q) > l;
        end
    end

    AST_ORDER_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |-> (int'(cnt_q) < DEPTH)); // R8
    AST_POP_WITHIN: assert property (@(posedge clk) disable iff (!rst_n)
        pop_n_i <= cnt_q); // R3
endmodule

// File: rtl/coal_intake.sv
`timescale 1ns/1ps
module coal_intake
    import coal_pkg::*;
#(
    parameter int NPORT = 4,
    parameter int VAW   = 32,
    parameter int PGB   = 12,
    parameter int SLOTS = 4,
    parameter int KEYW  = 8,
    parameter int PORTW = 2,
    parameter int IDW   = 2
) (
    input  logic [NPORT-1:0]     req_valid_i,
    input  logic [NPORT*VAW-1:0] req_vaddr_i,
    input  logic                 off_i,
    input  logic [KEYW-1:0]      cur_key_i,
    input  slot_st_e             st_i   [SLOTS],
    input  logic [VAW-PGB-1:0]   vpn_i  [SLOTS],
    input  logic [KEYW-1:0]      key_i  [SLOTS],
    input  logic                 full_i [SLOTS],
    output logic [NPORT-1:0]     req_ready_o,
    output logic                 acc_o,
    output logic                 join_o,
    output logic [IDW-1:0]       tgt_o,
    output logic [PORTW-1:0]     port_o,
    output logic [VAW-1:0]       vaddr_o
);
    logic             gv, hit, free, ok;
    logic [PORTW-1:0] gp;
    logic [IDW-1:0]   hslot, fslot;
    logic [VAW-1:0]   g_va;

    always_comb begin
        gv = 1'b0;
        gp = '0;
        for (int i = NPORT - 1; i >= 0; i--) begin
            if (req_valid_i[i]) begin
                gv = 1'b1;
                gp = PORTW'(i);
            end
        end
        g_va = req_vaddr_i[gp*VAW +: VAW];

        hit   = 1'b0;
        hslot = '0;
        free  = 1'b0;
        fslot = '0;
        for (int s = SLOTS - 1; s >= 0; s--) begin
            if (!off_i && st_i[s] == SL_PEND && key_i[s] == cur_key_i &&
                vpn_i[s] == g_va[VAW-1:PGB]) begin
                hit   = 1'b1;
                hslot = IDW'(s);
            end
            if (st_i[s] == SL_FREE) begin
                free  = 1'b1;
                fslot = IDW'(s);
            end
        end

        ok = gv && (hit ? !full_i[hslot] : free);
        req_ready_o = '0;
        if (ok) req_ready_o[gp] = 1'b1;
        acc_o   = ok;
        join_o  = hit;
        tgt_o   = hit ? hslot : fslot;
        port_o  = gp;
        vaddr_o = g_va;
    end
endmodule

// File: rtl/tlb_req_coalescer.sv
`timescale 1ns/1ps
module tlb_req_coalescer
    import coal_pkg::*;
#(
    parameter int NPORT = 4,
    parameter int VAW   = 32,
    parameter int PGB   = 12,
    parameter int PPNW  = 20,
    parameter int TAGW  = 4,
    parameter int SLOTS = 4,
    parameter int MEMB  = 4,
    parameter int LANES = 2,
    parameter int WIN   = 1,
    parameter int KEYW  = 8,
    parameter int VPNW  = VAW - PGB,
    parameter int IDW   = (SLOTS > 1) ? $clog2(SLOTS) : 1,
    parameter int PORTW = (NPORT > 1) ? $clog2(NPORT) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  coalesce_off,
    input  logic [NPORT-1:0]      req_valid,
    output logic [NPORT-1:0]      req_ready,
    input  logic [NPORT*VAW-1:0]  req_vaddr,
    input  logic [NPORT*TAGW-1:0] req_tag,
    output logic [LANES-1:0]      lk_valid,
    output logic [LANES*VPNW-1:0] lk_vpn,
    output logic [LANES*IDW-1:0]  lk_id,
    input  logic                  tr_valid,
    input  logic [IDW-1:0]        tr_id,
    input  logic [PPNW-1:0]       tr_ppn,
    output logic                  resp_valid,
    output logic [PORTW-1:0]      resp_port,
    output logic [TAGW-1:0]       resp_tag,
    output logic [PPNW+PGB-1:0]   resp_paddr
);
    localparam int SUBW = (WIN > 1) ? $clog2(WIN) : 1;
    localparam int CW   = $clog2(SLOTS + 1);

    // window counter
    logic [SUBW-1:0] sub_q;
    logic [KEYW-1:0] cur_key;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sub_q   <= '0;
            cur_key <= '0;
        end else if (sub_q == SUBW'(WIN - 1)) begin
            sub_q   <= '0;
            cur_key <= cur_key + 1'b1;
        end else begin
            sub_q <= sub_q + 1'b1;
        end
    end

    // slot views
    slot_st_e         s_st   [SLOTS];
    logic [VPNW-1:0]  s_vpn  [SLOTS];
    logic [KEYW-1:0]  s_key  [SLOTS];
    logic             s_full [SLOTS];
    logic [PPNW-1:0]  s_ppn  [SLOTS];
    logic [PGB-1:0]   s_off  [SLOTS];
    logic [PORTW-1:0] s_port [SLOTS];
    logic [TAGW-1:0]  s_tag  [SLOTS];
    logic [SLOTS-1:0] s_issue;

    // intake
    logic             acc, join_hit;
    logic [IDW-1:0]   tgt;
    logic [PORTW-1:0] in_port;
    logic [VAW-1:0]   in_va;
    logic [TAGW-1:0]  in_tag;

    coal_intake #(
        .NPORT(NPORT), .VAW(VAW), .PGB(PGB), .SLOTS(SLOTS),
        .KEYW(KEYW), .PORTW(PORTW), .IDW(IDW)
    ) u_intake (
        .req_valid_i (req_valid),
        .req_vaddr_i (req_vaddr),
        .off_i       (coalesce_off),
        .cur_key_i   (cur_key),
        .st_i        (s_st),
        .vpn_i       (s_vpn),
        .key_i       (s_key),
        .full_i      (s_full),
        .req_ready_o (req_ready),
        .acc_o       (acc),
        .join_o      (join_hit),
        .tgt_o       (tgt),
        .port_o      (in_port),
        .vaddr_o     (in_va)
    );

    assign in_tag = req_tag[in_port*TAGW +: TAGW];

    // creation order of pending groups
    logic [IDW-1:0] lane_id [LANES];
    logic           lane_ok [LANES];
    logic [CW-1:0]  pop_n;

    coal_order_fifo #(
        .DEPTH(SLOTS), .IDW(IDW), .LANES(LANES), .CW(CW)
    ) u_order (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_i    (acc && !join_hit),
        .push_id_i (tgt),
        .pop_n_i   (pop_n),
        .lane_id_o (lane_id),
        .lane_ok_o (lane_ok)
    );

    // issue lanes: prefix of the order queue whose window has closed
    always_comb begin
        logic go;
        go       = 1'b1;
        pop_n    = '0;
        s_issue  = '0;
        lk_valid = '0;
        lk_vpn   = '0;
        lk_id    = '0;
        for (int l = 0; l < LANES; l++) begin
            go = go && lane_ok[l] && (s_key[lane_id[l]] != cur_key);
            if (go) begin
                lk_valid[l]               = 1'b1;
                lk_vpn[l*VPNW +: VPNW]    = s_vpn[lane_id[l]];
                lk_id[l*IDW +: IDW]       = lane_id[l];
                pop_n                     = pop_n + 1'b1;
                s_issue[lane_id[l]]       = 1'b1;
            end
        end
    end

    // response fan-out: lowest slot in FANOUT drives the response port
    logic           fsel_v;
    logic [IDW-1:0] fsel;

    always_comb begin
        fsel_v = 1'b0;
        fsel   = '0;
        for (int s = SLOTS - 1; s >= 0; s--) begin
            if (s_st[s] == SL_FAN) begin
                fsel_v = 1'b1;
                fsel   = IDW'(s);
            end
        end
        resp_valid = fsel_v;
        resp_port  = s_port[fsel];
        resp_tag   = s_tag[fsel];
        resp_paddr = {s_ppn[fsel], s_off[fsel]};
    end

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        coal_slot #(
            .VPNW(VPNW), .PPNW(PPNW), .OFFW(PGB), .PORTW(PORTW),
            .TAGW(TAGW), .KEYW(KEYW), .MEMB(MEMB)
        ) u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .alloc_i (acc && !join_hit && tgt == IDW'(s)),
            .join_i  (acc && join_hit && tgt == IDW'(s)),
            .issue_i (s_issue[s]),
            .hit_i   (tr_valid && tr_id == IDW'(s)),
            .pop_i   (fsel_v && fsel == IDW'(s)),
            .vpn_i   (in_va[VAW-1:PGB]),
            .key_i   (cur_key),
            .off_i   (in_va[PGB-1:0]),
            .port_i  (in_port),
            .tag_i   (in_tag),
            .ppn_i   (tr_ppn),
            .st_o    (s_st[s]),
            .vpn_o   (s_vpn[s]),
            .key_o   (s_key[s]),
            .full_o  (s_full[s]),
            .ppn_o   (s_ppn[s]),
            .off_o   (s_off[s]),
            .port_o  (s_port[s]),
            .tag_o   (s_tag[s])
        );
    end

    AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(req_valid & req_ready)); // R9
    AST_READY_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready & ~req_valid) == '0); // R9
endmodule

// File: tb/test_tlb_req_coalescer.sv
`timescale 1ns/1ps
module test_tlb_req_coalescer;
    localparam int NP    = 3;
    localparam int VAW   = 20;
    localparam int PGB   = 8;
    localparam int VPNW  = VAW - PGB;
    localparam int PPNW  = 12;
    localparam int TAGW  = 4;
    localparam int SLOTS = 4;
    localparam int MEMB  = 3;
    localparam int LANES = 2;
    localparam int WIN   = 4;
    localparam int IDW   = 2;
    localparam int PORTW = 2;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  coalesce_off = 1'b0;
    logic [NP-1:0]         req_valid = '0;
    logic [NP-1:0]         req_ready;
    logic [NP*VAW-1:0]     req_vaddr = '0;
    logic [NP*TAGW-1:0]    req_tag = '0;
    logic [LANES-1:0]      lk_valid;
    logic [LANES*VPNW-1:0] lk_vpn;
    logic [LANES*IDW-1:0]  lk_id;
    logic                  tr_valid = 1'b0;
    logic [IDW-1:0]        tr_id = '0;
    logic [PPNW-1:0]       tr_ppn = '0;
    logic                  resp_valid;
    logic [PORTW-1:0]      resp_port;
    logic [TAGW-1:0]       resp_tag;
    logic [PPNW+PGB-1:0]   resp_paddr;

    tlb_req_coalescer #(
        .NPORT(NP), .VAW(VAW), .PGB(PGB), .PPNW(PPNW), .TAGW(TAGW),
        .SLOTS(SLOTS), .MEMB(MEMB), .LANES(LANES), .WIN(WIN), .KEYW(8)
    ) i_tlb_req_coalescer (.*);

    always #10 clk = ~clk;

    int checks = 0, fails = 0, cyc = 0;
    bit done = 1'b0;
    bit hold = 1'b0, rnd_gate = 1'b0;
    bit          exp_live [NP][16];
    logic [VAW-1:0] exp_va [NP][16];
    int ntag [NP];
    int lk_n = 0, rn = 0;
    logic [VPNW-1:0] log_vpn [1024];
    int log_cyc [1024];
    int rlog_tag [1024], rlog_cyc [1024];
    logic [IDW-1:0]  q_id [64];
    logic [VPNW-1:0] q_vpn [64];
    int qh = 0, qt = 0;

    function automatic logic [PPNW-1:0] ppn_of(input logic [VPNW-1:0] v);
        return v ^ 12'hA5C;
    endfunction

    function automatic logic [VAW-1:0] mk(input int vpn, input int off);
        return {VPNW'(vpn), PGB'(off)};
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic rec(input int p, input logic [VAW-1:0] va);
        exp_live[p][ntag[p]] = 1'b1;
        exp_va[p][ntag[p]]   = va;
        ntag[p] = (ntag[p] + 1) % 16;
    endtask

    // called at a falling edge; returns at a falling edge with valid low
    task automatic send(input int p, input logic [VAW-1:0] va, output int waits);
        waits = 0;
        req_valid[p] = 1'b1;
        req_vaddr[p*VAW +: VAW] = va;
        req_tag[p*TAGW +: TAGW] = TAGW'(ntag[p]);
        #2;
        while (!req_ready[p]) begin
            @(negedge clk); #2;
            waits++;
        end
        rec(p, va);
        @(negedge clk);
        req_valid[p] = 1'b0;
    endtask

    task automatic align();
        @(negedge clk);
        while (cyc % WIN != 0) @(negedge clk);
    endtask

    always @(posedge clk) if (rst_n) cyc <= cyc + 1;

    // monitor: lookups and member responses
    initial begin
        forever begin
            @(negedge clk); #5;
            for (int l = 0; l < LANES; l++) begin
                if (lk_valid[l]) begin
                    log_vpn[lk_n % 1024] = lk_vpn[l*VPNW +: VPNW];
                    log_cyc[lk_n % 1024] = cyc;
                    lk_n++;
                    q_id[qt % 64]  = lk_id[l*IDW +: IDW];
                    q_vpn[qt % 64] = lk_vpn[l*VPNW +: VPNW];
                    qt++;
                end
            end
            if (resp_valid) begin
                int p, t;
                logic [PPNW+PGB-1:0] e;
                p = int'(resp_port);
                t = int'(resp_tag);
                if (p < NP && exp_live[p][t]) begin
                    e = {ppn_of(exp_va[p][t][VAW-1:PGB]), exp_va[p][t][PGB-1:0]};
                    chk(resp_paddr == e, "R7", int'(resp_paddr), int'(e));
                    exp_live[p][t] = 1'b0;
                end else begin
                    chk(1'b0, "R7", p * 16 + t, -1);
                end
                rlog_tag[rn % 1024] = t;
                rlog_cyc[rn % 1024] = cyc;
                rn++;
            end
        end
    end

    // TLB model: answers queued lookups one per cycle
    initial begin
        forever begin
            @(negedge clk);
            tr_valid = 1'b0;
            if (!hold && qh != qt && (!rnd_gate || ($urandom % 2 == 0))) begin
                tr_valid = 1'b1;
                tr_id    = q_id[qh % 64];
                tr_ppn   = ppn_of(q_vpn[qh % 64]);
                qh++;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        int b, rb, tg, w, t0;
        logic [VAW-1:0] cur_va [NP];
        bit busy [NP], acc [NP];
        void'($urandom(32'h5EED_0123));
        for (int p = 0; p < NP; p++) begin
            ntag[p] = 0;
            busy[p] = 1'b0;
            acc[p]  = 1'b0;
            for (int t = 0; t < 16; t++) exp_live[p][t] = 1'b0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #5;
        chk(lk_valid == '0, "R11", int'(lk_valid), 0);
        chk(resp_valid == 1'b0, "R11", int'(resp_valid), 0);

        // R1 / R2 / R7: three members of one page in one window
        align(); t0 = cyc; b = lk_n; rb = rn; tg = ntag[0];
        send(0, mk(12'h011, 8'h01), w);
        send(0, mk(12'h011, 8'h22), w);
        send(0, mk(12'h011, 8'h33), w);
        repeat (16) @(negedge clk);
        chk(lk_n - b == 1, "R1", lk_n - b, 1);
        chk(log_cyc[b % 1024] == t0 + WIN, "R2", log_cyc[b % 1024], t0 + WIN);
        chk(rn - rb == 3, "R7", rn - rb, 3);
        for (int k = 0; k < 3; k++)
            chk(rlog_tag[(rb + k) % 1024] == (tg + k) % 16, "R7",
                rlog_tag[(rb + k) % 1024], (tg + k) % 16);
        chk(rlog_cyc[rb % 1024] == log_cyc[b % 1024] + 2, "R7",
            rlog_cyc[rb % 1024], log_cyc[b % 1024] + 2);

        // R4: merging switched off
        coalesce_off = 1'b1;
        align(); b = lk_n;
        send(1, mk(12'h044, 8'h10), w);
        send(1, mk(12'h044, 8'h20), w);
        send(1, mk(12'h044, 8'h30), w);
        repeat (16) @(negedge clk);
        chk(lk_n - b == 3, "R4", lk_n - b, 3);
        coalesce_off = 1'b0;

        // R3 / R5: three pages in one window, two lanes
        align(); t0 = cyc; b = lk_n;
        send(0, mk(12'h021, 8'h00), w);
        send(0, mk(12'h022, 8'h00), w);
        send(0, mk(12'h023, 8'h00), w);
        repeat (16) @(negedge clk);
        chk(lk_n - b == 3, "R3", lk_n - b, 3);
        chk(log_vpn[b % 1024] == 12'h021, "R5", int'(log_vpn[b % 1024]), 'h21);
        chk(log_vpn[(b + 1) % 1024] == 12'h022, "R5", int'(log_vpn[(b + 1) % 1024]), 'h22);
        chk(log_cyc[(b + 1) % 1024] == t0 + WIN, "R3", log_cyc[(b + 1) % 1024], t0 + WIN);
        chk(log_cyc[(b + 2) % 1024] == t0 + WIN + 1, "R3", log_cyc[(b + 2) % 1024], t0 + WIN + 1);

        // R2: same page across a window boundary
        align(); b = lk_n;
        repeat (WIN - 1) @(negedge clk);
        send(2, mk(12'h055, 8'h01), w);
        send(2, mk(12'h055, 8'h02), w);
        repeat (16) @(negedge clk);
        chk(lk_n - b == 2, "R2", lk_n - b, 2);

        // R6: page already outstanding
        hold = 1'b1;
        align(); b = lk_n; rb = rn;
        send(0, mk(12'h066, 8'h01), w);
        repeat (WIN + 1) @(negedge clk);
        send(0, mk(12'h066, 8'h02), w);
        repeat (12) @(negedge clk);
        chk(lk_n - b == 2, "R6", lk_n - b, 2);
        hold = 1'b0;
        repeat (12) @(negedge clk);
        chk(rn - rb == 2, "R6", rn - rb, 2);

        // R8: group full
        align();
        send(1, mk(12'h077, 8'h01), w);
        send(1, mk(12'h077, 8'h02), w);
        send(1, mk(12'h077, 8'h03), w);
        req_valid[1] = 1'b1;
        req_vaddr[1*VAW +: VAW] = mk(12'h077, 8'h04);
        req_tag[1*TAGW +: TAGW] = TAGW'(ntag[1]);
        #2;
        chk(req_ready[1] == 1'b0, "R8", int'(req_ready[1]), 0);
        @(negedge clk);
        send(1, mk(12'h077, 8'h04), w);
        repeat (20) @(negedge clk);

        // R8: no free slot
        hold = 1'b1;
        align();
        for (int k = 0; k < SLOTS; k++) send(0, mk(12'h080 + k, 8'h05), w);
        req_valid[0] = 1'b1;
        req_vaddr[0 +: VAW] = mk(12'h090, 8'h05);
        req_tag[0 +: TAGW] = TAGW'(ntag[0]);
        #2;
        chk(req_ready[0] == 1'b0, "R8", int'(req_ready[0]), 0);
        hold = 1'b0;
        @(negedge clk);
        send(0, mk(12'h090, 8'h05), w);
        repeat (30) @(negedge clk);

        // R9: fixed priority
        req_valid[1] = 1'b1; req_vaddr[1*VAW +: VAW] = mk(12'h0A1, 8'h01);
        req_tag[1*TAGW +: TAGW] = TAGW'(ntag[1]);
        req_valid[2] = 1'b1; req_vaddr[2*VAW +: VAW] = mk(12'h0A2, 8'h02);
        req_tag[2*TAGW +: TAGW] = TAGW'(ntag[2]);
        #2;
        chk(req_ready[1] == 1'b1 && req_ready[2] == 1'b0, "R9", int'(req_ready), 2);
        if (req_ready[1]) rec(1, mk(12'h0A1, 8'h01));
        @(negedge clk);
        req_valid[1] = 1'b0;
        #2;
        chk(req_ready[2] == 1'b1, "R9", int'(req_ready[2]), 1);
        if (req_ready[2]) rec(2, mk(12'h0A2, 8'h02));
        @(negedge clk);
        req_valid[2] = 1'b0;
        repeat (20) @(negedge clk);

        // R10: all slots released
        align();
        for (int k = 0; k < SLOTS; k++) begin
            send(2, mk(12'h0B0 + k, 8'h07), w);
            chk(w == 0, "R10", w, 0);
        end
        repeat (20) @(negedge clk);

        // random mix across ports, merging on then off
        rnd_gate = 1'b1;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (i == 1500) coalesce_off = 1'b1;
            for (int p = 0; p < NP; p++) begin
                if (acc[p]) begin
                    acc[p] = 1'b0;
                    busy[p] = 1'b0;
                    req_valid[p] = 1'b0;
                end
                if (!busy[p] && ($urandom % 3 == 0) && !exp_live[p][ntag[p]]) begin
                    busy[p] = 1'b1;
                    cur_va[p] = mk($urandom % 6, $urandom % 256);
                    req_vaddr[p*VAW +: VAW] = cur_va[p];
                    req_tag[p*TAGW +: TAGW] = TAGW'(ntag[p]);
                    req_valid[p] = 1'b1;
                end
            end
            #2;
            for (int p = 0; p < NP; p++) begin
                if (busy[p] && req_ready[p]) begin
                    rec(p, cur_va[p]);
                    acc[p] = 1'b1;
                end
            end
        end
        @(negedge clk);
        req_valid = '0;
        rnd_gate = 1'b0;
        coalesce_off = 1'b0;
        repeat (200) @(negedge clk);
        for (int p = 0; p < NP; p++)
            for (int t = 0; t < 16; t++)
                chk(!exp_live[p][t], "R7", p * 16 + t, -1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule